// File: doc/BRIEF.md
# Round-Robin Lane Striper with Alignment Markers

This block takes a stream of 66-bit encoded blocks, one per accepted beat, and deals them out across a parameterised number of virtual lanes. The first accepted block goes to lane 0, the next to lane 1, and so on. After the last lane it wraps back to lane 0. Once every lane of a round is filled, the whole round is presented at once on a wide output bus for one cycle, qualified by a single group strobe. Typical builds use 4 lanes for the lower rate or 20 lanes for the higher rate.

At a fixed spacing counted in rounds, the block emits a marker round in place of data. In that round every lane carries a word that names the lane, so a receiver can identify and deskew each lane. All lanes carry their markers in the same round. While a marker round is being produced, the upstream ready is held low for exactly one cycle, so no data block is lost or reordered.

The controller is a two-state machine:
- **MARK** is entered on reset and after the last data round of a period. It emits the marker round and always moves to DATA on the next clock.
- **DATA** accepts blocks. It stays in DATA until the round that completes the period, then returns to MARK.

Top module: `lane_striper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `in_ready` and `out_valid` are low. The first group emitted after reset is a marker round. Reset is synchronous. A reset in mid-round discards the partial round, and the next data block goes to lane 0.
- R2: Within a round, the k-th accepted block (counting from 0) appears in lane k, which is `out_lanes[66*k+65 : 66*k]`. Blocks keep their arrival order across rounds.
- R3: `out_valid` rises, with `out_marker` low, in the cycle right after the clock edge that accepts the block for lane LANES-1. It is high for that one cycle only, unless a marker round follows at once.
- R4: Each marker word has three fields:
  - bits [65:64] hold 2'b10;
  - bits [63:56] hold the lane number;
  - bits [55:48] hold the bitwise inverse of the lane number.
  The low 48 bits of every lane hold 48'h5AC3960FE12D.
- R5: In a marker round, every lane carries its marker in the same output cycle, and `out_marker` is high together with `out_valid`.
- R6: Exactly AM_PERIOD-1 data rounds lie between two consecutive marker rounds. The spacing is counted in completed rounds, not in clock cycles, so an idle input never produces extra markers.
- R7: `in_ready` is low for exactly one cycle per marker round. It drops in the cycle after the edge that completes the last data round of a period. The marker round appears on the output in the next cycle.
- R8: Cycles with `in_valid` low leave the lane pointer and the round count unchanged, so gaps in the input do not change lane assignment or marker spacing.
- R9: With LANES = 20, striping and marker lane numbers 0 to 19 follow R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream block present |
| in_block | input | 66 | Encoded block, sync header in bits [65:64] |
| in_ready | output | 1 | Block accepted when high with `in_valid` |
| out_valid | output | 1 | One-cycle strobe for a complete lane group |
| out_marker | output | 1 | Current group is a marker round |
| out_lanes | output | LANES*66 | Lane k in bits [66k+65:66k] |

## Verification
The bench builds two copies of the block.
- The first uses 4 lanes and a marker spacing of 4 rounds. Several full marker periods then fit in a few dozen cycles, which brings within reach the wrap of the lane pointer, back-to-back data and marker groups, stalls caused by gaps in the input, and a reset in the middle of a round.
- The second uses 20 lanes and a spacing of 3. It exercises the wide lane layout and the higher marker lane numbers, and brings a second period value into the spacing check.

// File: rtl/lstripe_pkg.sv
package lstripe_pkg;
    localparam int BLK_W = 66;
    localparam logic [1:0]  MARK_SYNC = 2'b10;
    localparam logic [47:0] MARK_FILL = 48'h5AC3_960F_E12D;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [0:0] {
        ST_MARK = 1'b0,
        ST_DATA = 1'b1
    } lstripe_state_e;

    function automatic blk_t make_marker(input logic [7:0] lane_id);
        return {MARK_SYNC, lane_id, ~lane_id, MARK_FILL};
    endfunction
endpackage

// File: rtl/lstripe_rr_gather.sv
module lstripe_rr_gather
    import lstripe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  blk_t                         blk,
    output logic                         last,
    output logic [(LANES-1)*BLK_W-1:0]   held
);
    localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [PW-1:0] ptr;

    assign last = (ptr == PW'(LANES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (take) begin
            ptr <= last ? '0 : ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < LANES - 1; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (take && ptr == PW'(i)) begin
                held[i*BLK_W +: BLK_W] <= blk;
            end
        end
    end
endmodule

// File: rtl/lstripe_period_ctr.sv
module lstripe_period_ctr #(
    parameter int AM_PERIOD = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic at_end
);
    localparam int CW = (AM_PERIOD > 2) ? $clog2(AM_PERIOD - 1) : 1;

    logic [CW-1:0] cnt;

    assign at_end = (cnt == CW'(AM_PERIOD - 2));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lstripe_marker_gen.sv
module lstripe_marker_gen
    import lstripe_pkg::*;
#(
    parameter int LANES = 4
) (
    output logic [LANES*BLK_W-1:0] marks
);
    for (genvar i = 0; i < LANES; i++) begin : g_mark
        assign marks[i*BLK_W +: BLK_W] = make_marker(8'(i));
    end
endmodule

// File: rtl/lane_striper.sv
module lane_striper
    import lstripe_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int AM_PERIOD = 16384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [65:0]              in_block,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic                     out_marker,
    output logic [LANES*66-1:0]      out_lanes
);
    localparam int HW = (LANES - 1) * BLK_W;

    lstripe_state_e state, nxt;
    logic           take, last, round_done, at_end;
    logic [HW-1:0]  held;
    logic [LANES*BLK_W-1:0] marks;

    assign in_ready   = (state == ST_DATA);
    assign take       = in_valid && in_ready;
    assign round_done = take && last;

    lstripe_rr_gather #(.LANES(LANES)) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .blk   (in_block),
        .last  (last),
        .held  (held)
    );

    lstripe_period_ctr #(.AM_PERIOD(AM_PERIOD)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_MARK),
        .step   (round_done),
        .at_end (at_end)
    );

    lstripe_marker_gen #(.LANES(LANES)) u_markgen (
        .marks (marks)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MARK;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_MARK: nxt = ST_DATA;
            ST_DATA: nxt = (round_done && at_end) ? ST_MARK : ST_DATA;
            default: nxt = ST_MARK;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_marker <= 1'b0;
            out_lanes  <= '0;
        end else begin
            unique case (state)
                ST_MARK: begin
                    out_valid  <= 1'b1;
                    out_marker <= 1'b1;
                    out_lanes  <= marks;
                end
                ST_DATA: begin
                    out_valid  <= round_done;
                    out_marker <= 1'b0;
                    if (round_done) begin
                        out_lanes <= {in_block, held};
                    end
                end
                default: begin
                    out_valid  <= 1'b0;
                    out_marker <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lane_striper_chk.sv
module lane_striper_chk
    import lstripe_pkg::*;
#(
    parameter int AM_PERIOD = 16384
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_marker,
    input logic [65:0] lane0
);
    int   gap;
    logic seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (out_valid && out_marker) begin
            gap  <= 0;
            seen <= 1'b1;
        end else if (out_valid) begin
            gap <= gap + 1;
        end
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready); // R7
    AST_READY_GIVES_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && out_marker)); // R7
    AST_MARK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_marker |-> out_valid); // R5
    AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_marker) |=> (!out_valid || out_marker)); // R3
    AST_MARK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_marker |-> lane0 == {2'b10, 8'h00, 8'hFF, MARK_FILL}); // R4
    AST_MARK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_marker && seen) |-> gap == AM_PERIOD - 1); // R6
    AST_DATA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_marker) |-> gap < AM_PERIOD - 1); // R6
endmodule

bind lane_striper lane_striper_chk #(.AM_PERIOD(AM_PERIOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_marker (out_marker),
    .lane0      (out_lanes[65:0])
);

// File: tb/lane_striper_tb.sv
module lane_striper_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    int   tests = 0, fails = 0, cyc = 0;
    bit   done = 1'b0;
    always @(posedge clk) cyc++;

    // 4-lane instance, period 4
    logic         iv = 0, ird, ov, om;
    logic [65:0]  ib = '0;
    logic [263:0] ol;
    lane_striper #(.LANES(4), .AM_PERIOD(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_block(ib),
        .in_ready(ird), .out_valid(ov), .out_marker(om), .out_lanes(ol));

    // 20-lane instance, period 3
    logic          ivb = 0, irdb, ovb, omb;
    logic [65:0]   ibb = '0;
    logic [1319:0] olb;
    lane_striper #(.LANES(20), .AM_PERIOD(3)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .in_valid(ivb), .in_block(ibb),
        .in_ready(irdb), .out_valid(ovb), .out_marker(omb), .out_lanes(olb));

    logic [263:0]  ga [0:15];
    logic          gam [0:15];
    int            gac [0:15];
    int            gn = 0;
    logic [1319:0] gb [0:7];
    logic          gbm [0:7];
    int            gnb = 0;
    int            accc [0:63];
    int            nput = 0;
    int            rl_cnt = 0, rl_dbl = 0;
    logic          rl_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ov && gn < 16) begin
                ga[gn] = ol; gam[gn] = om; gac[gn] = cyc; gn++;
            end
            if (ovb && gnb < 8) begin
                gb[gnb] = olb; gbm[gnb] = omb; gnb++;
            end
            if (!ird) begin
                rl_cnt++;
                if (rl_prev) rl_dbl++;
            end
            rl_prev = !ird;
        end
    end

    function automatic logic [65:0] mkblk(input int i);
        return {2'b01, 32'(i), 32'hC0DE_0000 ^ 32'(i * 7)};
    endfunction

    function automatic logic [65:0] mkexp(input int j);
        return {2'b10, 8'(j), ~8'(j), 48'h5AC3_960F_E12D};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; iv = 0; ivb = 0;
        repeat (3) @(negedge clk);
        chk(!ird && !ov, "R1 in reset", {64'd0, ird, ov}, 66'd0);
        gn = 0; gnb = 0; nput = 0; rl_cnt = 0; rl_dbl = 0; rl_prev = 0;
        @(negedge clk);
        rst_n = 1;
        chk(!ird && !ov, "R1 first cycle", {64'd0, ird, ov}, 66'd0);
    endtask

    task automatic put(input logic [65:0] blk, input int gap);
        bit acc = 0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); iv = 0;
        end
        while (!acc) begin
            @(negedge clk);
            iv = 1; ib = blk; acc = ird;
            @(posedge clk);
            #1;
        end
        accc[nput] = cyc;
        nput++;
    endtask

    task automatic idle(input int n);
        @(negedge clk); iv = 0; ivb = 0;
        repeat (n) @(negedge clk);
    endtask

    // checks a 4-lane, period-4 capture against blocks base..base+nblk-1
    task automatic check_a(input int base, input int nblk, input string tag);
        int r = nblk / 4;
        int dk = 0;
        int mk = 0;
        chk(gn == r + 1 + r / 3, {tag, " R6 group count"}, 66'(gn), 66'(r + 1 + r / 3));
        for (int g = 0; g < gn; g++) begin
            if (g % 4 == 0) begin
                mk++;
                chk(gam[g], {tag, " R5 marker flag"}, 66'(gam[g]), 66'd1);
                for (int j = 0; j < 4; j++)
                    chk(ga[g][j*66 +: 66] == mkexp(j), {tag, " R4 marker word"}, ga[g][j*66 +: 66], mkexp(j));
                if (g > 0)
                    chk(gac[g] == gac[g-1] + 1, {tag, " R7 marker follows round"}, 66'(gac[g]), 66'(gac[g-1] + 1));
            end else begin
                chk(!gam[g], {tag, " R6 data flag"}, 66'(gam[g]), 66'd0);
                for (int j = 0; j < 4; j++)
                    chk(ga[g][j*66 +: 66] == mkblk(base + dk*4 + j), {tag, " R2 lane data"},
                        ga[g][j*66 +: 66], mkblk(base + dk*4 + j));
                chk(gac[g] == accc[dk*4 + 3], {tag, " R3 strobe cycle"}, 66'(gac[g]), 66'(accc[dk*4 + 3]));
                dk++;
            end
        end
        chk(rl_cnt == mk && rl_dbl == 0, {tag, " R7 ready low per marker"}, 66'(rl_cnt), 66'(mk));
    endtask

    task automatic t_continuous();
        do_reset();
        for (int i = 0; i < 24; i++) put(mkblk(i), 0);
        idle(5);
        check_a(0, 24, "continuous");
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 12; i++) put(mkblk(50 + i), i % 3);
        idle(5);
        check_a(50, 12, "gaps R8");
    endtask

    task automatic t_idle();
        do_reset();
        idle(20);
        chk(gn == 1 && gam[0], "R6 idle single marker", 66'(gn), 66'd1);
        chk(ird, "R8 ready while idle", 66'(ird), 66'd1);
    endtask

    task automatic t_mid_reset();
        do_reset();
        put(mkblk(100), 0);
        put(mkblk(101), 0);
        do_reset();
        for (int i = 0; i < 4; i++) put(mkblk(200 + i), 0);
        idle(4);
        check_a(200, 4, "mid reset R1");
    endtask

    task automatic t_wide();
        int dk = 0;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            bit acc = 0;
            while (!acc) begin
                @(negedge clk);
                ivb = 1; ibb = mkblk(300 + i); acc = irdb;
                @(posedge clk);
            end
        end
        idle(5);
        chk(gnb == 4, "R9 wide group count", 66'(gnb), 66'd4);
        for (int g = 0; g < gnb; g++) begin
            if (g % 3 == 0) begin
                chk(gbm[g], "R9 wide marker flag", 66'(gbm[g]), 66'd1);
                for (int j = 0; j < 20; j++)
                    chk(gb[g][j*66 +: 66] == mkexp(j), "R9 wide marker word", gb[g][j*66 +: 66], mkexp(j));
            end else begin
                for (int j = 0; j < 20; j++)
                    chk(gb[g][j*66 +: 66] == mkblk(300 + dk*20 + j), "R9 wide lane data",
                        gb[g][j*66 +: 66], mkblk(300 + dk*20 + j));
                dk++;
            end
        end
    endtask

    initial begin
        t_continuous();
        t_gaps();
        t_idle();
        t_mid_reset();
        t_wide();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule